// File: doc/BRIEF.md
# Start Control with Chained Start Pulse

This block decides when a sampled-data pipeline begins running. It accepts two active-low start requests. The first may arrive at any time, unrelated to the sample clock. The second is already aligned to the sample clock. Either one can start the block. The input that is not used is tied high.

After a start, a sticky run flag goes high. This flag enables the clock divider and the datapath downstream. Until the flag is high, those stages ignore incoming samples.

When the asynchronous request is used, it is first passed through a synchronizer. It is then re-exported as a single-cycle active-low start pulse. That pulse can be wired to the synchronous start input of further copies of the block. All copies then begin on the same sample-clock edge.

Each start event also produces a one-cycle clear strobe. This strobe releases the pipeline's disable bit. Only reset stops a running block.

Top module: `start_ctl`

## Requirements
- R1: While `rst` is high and on the first edge after it, `run` is 0, `start_out_n` is 1 and `dis_clr` is 0, whatever the start inputs do.
- R2: `astart_n` passes through ASYNC_STAGES flip-flops (default 2). If a low is first sampled at edge k, `start_out_n` is 0 between edges k+2 and k+3 only, exactly one sample-clock period.
- R3: One falling transition of `astart_n` gives exactly one `start_out_n` pulse, even if `astart_n` then stays low. A low lasting a single clock is still caught.
- R4: A start is counted only on a transition from high to low (a 1 sampled, then a 0). An input that is already low when reset is released, and stays low, never starts the block.
- R5: For the synchronous path, if `sstart_n` is first sampled low at edge j, then `run` rises at edge j+1. For the asynchronous path, `run` rises at edge k+4, one edge after the `start_out_n` pulse ends.
- R6: The internal start is the AND of `sstart_n` and the block's own `start_out_n`, so either path alone starts the block. Driving `sstart_n` produces no `start_out_n` pulse.
- R7: Once `run` is 1, it stays 1 through any later start events. Only `rst` returns it to 0. After reset, a new start event is needed.
- R8: Each start event raises `dis_clr` for exactly one cycle. The first event's `dis_clr` coincides with the rise of `run`.
- R9: With a master's `start_out_n` wired to a slave's `sstart_n`, the slave's `run` rises on the same edge as the master's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| astart_n | input | 1 | Asynchronous start request, active low |
| sstart_n | input | 1 | Clock-aligned start request, active low |
| start_out_n | output | 1 | One-cycle start pulse for chained copies, active low |
| run | output | 1 | Sticky run enable for divider and datapath |
| dis_clr | output | 1 | One-cycle strobe that clears the disable bit |

## Verification
The bench builds the block with the default two-stage synchronizer. This makes the edge numbers in R2, R5 and R9 exact and countable.

Two copies are instantiated in a master-and-slave chain. This lets the bench compare same-edge starting directly at the ports. It also shows that a start through `sstart_n` produces no chained pulse.

A table of per-cycle vectors covers:
- an initial asynchronous start;
- a later one-cycle restart pulse while already running.

Directed cases cover:
- an input held low across reset;
- a reset that halts a running block.

// File: rtl/start_ctl.sv
module start_ctl #(
  parameter int ASYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic astart_n,
  input  logic sstart_n,
  output logic start_out_n,
  output logic run,
  output logic dis_clr
);

  logic [ASYNC_STAGES:0] achain;
  logic                  a_fall;
  logic                  comb_n;
  logic                  s_now, s_prev;
  logic                  evt;

  // synchronizer plus one extra stage for edge detection; reset to 0 so a high must be seen first
  always_ff @(posedge clk or posedge rst)
    if (rst) achain <= '0;
    else     achain <= {achain[ASYNC_STAGES-1:0], astart_n};

  assign a_fall = achain[ASYNC_STAGES] & ~achain[ASYNC_STAGES-1];

  always_ff @(posedge clk or posedge rst)
    if (rst) start_out_n <= 1'b1;
    else     start_out_n <= ~a_fall;

  assign comb_n = sstart_n & start_out_n;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      s_now  <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_now  <= comb_n;
      s_prev <= s_now;
    end

  assign evt = s_prev & ~s_now;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      run     <= 1'b0;
      dis_clr <= 1'b0;
    end else begin
      run     <= run | evt;
      dis_clr <= evt;
    end

  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $fell(start_out_n) |=> start_out_n);  // R2
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    run |=> run);  // R7
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dis_clr |=> !dis_clr);  // R8
  AST_RISE_WITH_CLR: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> dis_clr);  // R8
  AST_NO_RUN_WITHOUT_CLR: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |-> dis_clr);  // R5

endmodule

// File: tb/tb_start_ctl.sv
module tb_start_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_n = 1'b1, s_n = 1'b1;
  logic m_out, m_run, m_clr, s_out, s_run, s_clr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  start_ctl dut (.clk(clk), .rst(rst), .astart_n(a_n), .sstart_n(s_n),
                 .start_out_n(m_out), .run(m_run), .dis_clr(m_clr));
  start_ctl slave (.clk(clk), .rst(rst), .astart_n(1'b1), .sstart_n(m_out),
                   .start_out_n(s_out), .run(s_run), .dis_clr(s_clr));

  // each entry: {astart_n, exp start_out_n, exp run, exp dis_clr, exp slave run}
  localparam logic [4:0] VEC [16] = '{
    5'b11000, 5'b11000, 5'b11000,
    5'b01000, 5'b01000, 5'b10000, 5'b11000,
    5'b11111, 5'b11101, 5'b11101,
    5'b01101, 5'b11101, 5'b10101, 5'b11101, 5'b11111, 5'b11101
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", {m_out, m_run, m_clr, s_run}, 4'b1000);
    @(negedge clk);
    a_n = 1'b0; s_n = 1'b0;
    @(negedge clk);
    chk("R1 reset ignores starts", {m_out, m_run, m_clr, s_run}, 4'b1000);
    a_n = 1'b1; s_n = 1'b1;
    rst = 1'b0;

    // R2 R3 R5 R7 R8 R9: async start then one-cycle restart while running
    for (int i = 0; i < 16; i++) begin
      a_n = VEC[i][4];
      @(negedge clk);
      chk($sformatf("R2/R5/R9 vec %0d", i), {m_out, m_run, m_clr, s_run}, VEC[i][3:0]);
    end
    a_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 held low gives one pulse", {m_out, m_clr}, 2'b10);
    a_n = 1'b1;

    // R7 reset halts, no restart without event
    do_reset();
    chk("R1 first edge after reset", {m_out, m_run, m_clr, s_run}, 4'b1000);
    repeat (5) @(negedge clk);
    chk("R7 stays stopped after reset", {m_run, s_run}, 2'b00);

    // R6 sync path: low sampled at edge j -> run at j+1, no chained pulse
    s_n = 1'b0;
    @(negedge clk);
    chk("R5 sync not yet", {m_out, m_run, m_clr}, 3'b100);
    @(negedge clk);
    chk("R6 sync starts", {m_out, m_run, m_clr, s_run}, 4'b1110);
    @(negedge clk);
    chk("R8 clr one cycle", {m_run, m_clr}, 2'b10);
    repeat (4) @(negedge clk);
    chk("R6 sync makes no start_out", {m_out, s_run}, 2'b10);

    // R4 held low across reset never starts
    @(negedge clk); rst = 1'b1; s_n = 1'b0;
    @(negedge clk); rst = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 low since reset no start", {m_run, m_clr}, 2'b00);
    s_n = 1'b1;
    repeat (2) @(negedge clk);
    s_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R4 high then low starts", {m_run, m_clr}, 2'b11);
    s_n = 1'b1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule